// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Byte Receiver

This block takes a single asynchronous serial line and recovers bytes framed as one low start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. A prescaler divides the system clock into a timing tick that runs at eight times the bit rate. The line passes through a two-flop synchroniser, and a high-to-low transition on the synchronised line starts a frame. After a short lead-in of three ticks, a bit-timing counter begins counting ticks. Sampling strobes are decoded from fixed counter values, so each one falls near the middle of a bit. The start bit is never captured.

Data samples enter the byte register at its top and shift towards bit 0. After the eighth data bit the stop bit is sampled. The receiver then presents the completed byte together with a framing-error flag and pulses a valid output for one clock. It then goes idle and waits for the next falling edge. Parent logic reads the byte on the valid pulse, or at any later time before the next byte completes.

Top module: `uart_os_rx`

## Requirements
- R1: Reset is active-low and asynchronous. During and after reset, `rx_valid` is 0, `rx_data` is 8'h00 and `rx_frame_err` is 0.
- R2: The eight data bits that follow the start bit are assembled least significant bit first. The first data bit on the line appears in `rx_data[0]` and the last one appears in `rx_data[7]`.
- R3: A frame begins only at a high-to-low transition of the synchronised line. The low start bit is not stored in `rx_data`.
- R4: Each data bit is sampled once, when the bit-timing counter reaches 9, 17, 25, 33, 41, 49, 57 or 65. These points lie 12 + 8*k ticks after the start-edge detection (k = 0..7), near the middle of each bit. A line excursion confined to the first fifth of a bit period does not change the received byte.
- R5: The stop bit is sampled when the counter reaches 73. A high stop bit gives `rx_frame_err` = 0.
- R6: A low stop bit gives `rx_frame_err` = 1, and the byte is still delivered with `rx_valid`.
- R7: `rx_valid` is high for exactly one clock per received frame. `rx_data` and `rx_frame_err` keep their values until the next frame completes.
- R8: After the stop sample the receiver is idle. A line that stays low after a frame does not start another frame. A new frame needs the line to return high and then fall again.
- R9: Transitions on the line during an active frame do not restart it. A start bit that immediately follows a stop bit is received as the next frame.
- R10: The tick period is CLK_HZ / (BAUD * 8) clocks. `rx_valid` rises 76 ticks, plus the synchroniser latency, after the line's start-bit falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-clock pulse when a byte completes |
| rx_frame_err | output | 1 | Set when the last byte's stop bit was low |

## Verification
The bench keeps the bit rate at 9600 baud and sets the nominal clock frequency to 307200 Hz. This makes one tick four clocks and one bit 32 clocks, so a full frame takes about 320 clocks. With that short frame, every data pattern in the vector table, back-to-back frames, a line held low after a bad stop bit, and a reset in the middle of a frame all fit in one short run. The four-clock tick also gives a known cycle window for the valid pulse. It leaves room to inject glitches early in each bit, well away from the sample points.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_LEAD  = 2'd1,
        RX_COUNT = 2'd2
    } rx_state_e;
endpackage

// File: rtl/uart_os_sync.sv
module uart_os_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = line_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign level_o = sync_q.s2;
    assign fall_o  = sync_q.s3 & ~sync_q.s2;

    // R3
    fall_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> $past(level_o));
endmodule

// File: rtl/uart_os_tick.sv
module uart_os_tick #(
    parameter int DIV = 651
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] div;
    } tick_t;

    tick_t tick_d, tick_q;

    always_comb begin
        tick_d = tick_q;
        if (restart_i || tick_q.div == LAST) tick_d.div = '0;
        else                                tick_d.div = tick_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

    assign tick_o = (tick_q.div == LAST) && !restart_i;

    // R10
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/uart_os_frame.sv
module uart_os_frame
    import uart_os_pkg::*;
#(
    parameter int OVERSAMPLE = 8,
    parameter int DATA_BITS  = 8,
    parameter int CNT_W      = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic tick_i,
    output logic restart_o,
    output logic data_stb_o,
    output logic stop_stb_o
);
    localparam int FIRST_CNT  = OVERSAMPLE + 1;
    localparam int STOP_CNT   = FIRST_CNT + DATA_BITS * OVERSAMPLE;
    localparam int LEAD_TICKS = OVERSAMPLE / 2 - 1;

    typedef struct packed {
        rx_state_e      state;
        logic [CNT_W-1:0] cnt;
    } frame_t;

    frame_t fr_d, fr_q;
    logic [CNT_W-1:0]     cnt_nx;
    logic [DATA_BITS-1:0] hit;
    logic                 stop_hit;

    assign cnt_nx = fr_q.cnt + 1'b1;

    for (genvar g = 0; g < DATA_BITS; g++) begin : g_hit
        assign hit[g] = (cnt_nx == CNT_W'(FIRST_CNT + g * OVERSAMPLE));
    end
    assign stop_hit = (cnt_nx == CNT_W'(STOP_CNT));

    assign restart_o  = fall_i && (fr_q.state == RX_IDLE);
    assign data_stb_o = (fr_q.state == RX_COUNT) && tick_i && (|hit);
    assign stop_stb_o = (fr_q.state == RX_COUNT) && tick_i && stop_hit;

    always_comb begin
        fr_d = fr_q;
        unique case (fr_q.state)
            RX_IDLE: begin
                if (fall_i) begin
                    fr_d.cnt   = '0;
                    fr_d.state = (LEAD_TICKS > 0) ? RX_LEAD : RX_COUNT;
                end
            end
            RX_LEAD: begin
                if (tick_i) begin
                    if (cnt_nx == CNT_W'(LEAD_TICKS)) begin
                        fr_d.cnt   = '0;
                        fr_d.state = RX_COUNT;
                    end else begin
                        fr_d.cnt = cnt_nx;
                    end
                end
            end
            RX_COUNT: begin
                if (tick_i) begin
                    fr_d.cnt = cnt_nx;
                    if (stop_hit) begin
                        fr_d.cnt   = '0;
                        fr_d.state = RX_IDLE;
                    end
                end
            end
            default: fr_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '{state: RX_IDLE, cnt: '0};
        else        fr_q <= fr_d;
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.cnt <= CNT_W'(STOP_CNT));
    // R8
    idle_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb_o |=> fr_q.state == RX_IDLE);
    // R9
    no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.state == RX_COUNT && fall_i && !tick_i) |=> fr_q.state == RX_COUNT);
endmodule

// File: rtl/uart_os_shift.sv
module uart_os_shift #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 level_i,
    input  logic                 data_stb_i,
    input  logic                 stop_stb_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 ferr_o
);
    localparam int SW = $clog2(DATA_BITS + 1);

    typedef struct packed {
        logic [DATA_BITS-1:0] sh;
        logic [DATA_BITS-1:0] data;
        logic                 valid;
        logic                 ferr;
        logic [SW-1:0]        nsamp;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d       = sh_q;
        sh_d.valid = 1'b0;
        if (data_stb_i) begin
            sh_d.sh    = {level_i, sh_q.sh[DATA_BITS-1:1]};
            sh_d.nsamp = sh_q.nsamp + 1'b1;
        end
        if (stop_stb_i) begin
            sh_d.data  = sh_q.sh;
            sh_d.ferr  = ~level_i;
            sh_d.valid = 1'b1;
            sh_d.nsamp = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign data_o  = sh_q.data;
    assign valid_o = sh_q.valid;
    assign ferr_o  = sh_q.ferr;

    // R4
    eight_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb_i |-> sh_q.nsamp == SW'(DATA_BITS));
    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(data_o) && $stable(ferr_o)));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int BAUD       = 9600,
    parameter int OVERSAMPLE = 8,
    parameter int DATA_BITS  = 8,
    parameter int CNT_W      = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err
);
    localparam int CLKS_PER_TICK = CLK_HZ / (BAUD * OVERSAMPLE);

    logic level, fall, restart, tick, data_stb, stop_stb;

    uart_os_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (rx_line),
        .level_o (level),
        .fall_o  (fall)
    );

    uart_os_tick #(.DIV(CLKS_PER_TICK)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .tick_o    (tick)
    );

    uart_os_frame #(
        .OVERSAMPLE (OVERSAMPLE),
        .DATA_BITS  (DATA_BITS),
        .CNT_W      (CNT_W)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall),
        .tick_i     (tick),
        .restart_o  (restart),
        .data_stb_o (data_stb),
        .stop_stb_o (stop_stb)
    );

    uart_os_shift #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (level),
        .data_stb_i (data_stb),
        .stop_stb_i (stop_stb),
        .data_o     (rx_data),
        .valid_o    (rx_valid),
        .ferr_o     (rx_frame_err)
    );

    // R5
    valid_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(stop_stb));
    // R6
    ferr_from_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_frame_err == !$past(level));
endmodule

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;
    localparam int BIT_CLKS = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_err;

    int n_tests = 0;
    int n_fail  = 0;
    int vcount  = 0;
    int wide    = 0;
    int cycles  = 0;
    logic       prev_valid = 1'b0;
    logic [7:0] cap_data = '0, cap_prev = '0;
    logic       cap_err = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    uart_os_rx #(.CLK_HZ(307_200), .BAUD(9600)) u_uart_os_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_line      (rx_line),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && rx_valid) begin
            vcount   <= vcount + 1;
            cap_prev <= cap_data;
            cap_data <= rx_data;
            cap_err  <= rx_frame_err;
            if (prev_valid) wide <= wide + 1;
        end
        prev_valid <= rx_valid;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int n);
        @(posedge clk); #1 rx_line = v;
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic stop, input bit glitch);
        drive(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            if (glitch) begin
                drive(~d[i], 6);
                drive(d[i], BIT_CLKS - 6);
            end else begin
                drive(d[i], BIT_CLKS);
            end
        end
        drive(stop, BIT_CLKS);
    endtask

    localparam logic [9:0] VEC [0:7] = '{
        {8'hA5, 1'b1, 1'b0}, {8'h00, 1'b1, 1'b0}, {8'hFF, 1'b1, 1'b0},
        {8'h55, 1'b1, 1'b0}, {8'hAA, 1'b1, 1'b0}, {8'h01, 1'b1, 1'b0},
        {8'h80, 1'b1, 1'b0}, {8'h3C, 1'b0, 1'b1}
    };

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        int v0, t0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        check(rx_valid == 0 && rx_data == 8'h00 && rx_frame_err == 0, "R1", rx_data, 0);
        #1 rst_n = 1'b1;
        drive(1'b1, 20);

        // R2 R3 R5 R6 vectors
        foreach (VEC[k]) begin
            v0 = vcount;
            send(VEC[k][9:2], VEC[k][1], 1'b0);
            drive(1'b1, 40);
            @(negedge clk);
            check(vcount == v0 + 1, "R7", vcount - v0, 1);
            check(cap_data == VEC[k][9:2], "R2", cap_data, VEC[k][9:2]);
            check(cap_err == VEC[k][0], VEC[k][0] ? "R6" : "R5", cap_err, VEC[k][0]);
        end
        check(wide == 0, "R7", wide, 0);

        // R7 hold after idle
        drive(1'b1, 100);
        @(negedge clk);
        check(rx_data == 8'h3C && rx_frame_err == 1, "R7", rx_data, 8'h3C);

        // R4 glitches early in each bit
        send(8'hC3, 1'b1, 1'b1);
        drive(1'b1, 40);
        @(negedge clk);
        check(cap_data == 8'hC3 && !cap_err, "R4", cap_data, 8'hC3);

        // R8 line held low after bad stop
        v0 = vcount;
        send(8'h00, 1'b0, 1'b0);
        drive(1'b0, 400);
        @(negedge clk);
        check(vcount == v0 + 1, "R8", vcount - v0, 1);
        drive(1'b1, 40);
        send(8'h5A, 1'b1, 1'b0);
        drive(1'b1, 40);
        @(negedge clk);
        check(vcount == v0 + 2 && cap_data == 8'h5A, "R8", cap_data, 8'h5A);

        // R9 back-to-back frames
        v0 = vcount;
        send(8'h12, 1'b1, 1'b0);
        send(8'h34, 1'b1, 1'b0);
        drive(1'b1, 40);
        @(negedge clk);
        check(vcount == v0 + 2, "R9", vcount - v0, 2);
        check(cap_prev == 8'h12 && cap_data == 8'h34, "R9", {cap_prev, cap_data}, 16'h1234);

        // R10 valid latency from start edge
        @(posedge clk); #1 rx_line = 1'b0;
        t0 = cycles;
        v0 = vcount;
        fork
            begin
                repeat (BIT_CLKS - 1) @(posedge clk);
                for (int i = 0; i < 8; i++) drive(1'b1, BIT_CLKS);
                drive(1'b1, BIT_CLKS);
            end
            begin
                while (vcount == v0 && cycles - t0 < 600) @(negedge clk);
            end
        join
        check(vcount == v0 + 1, "R10", vcount - v0, 1);
        drive(1'b1, 20);

        // R10 exact window
        @(posedge clk); #1 rx_line = 1'b0;
        t0 = cycles;
        while (!rx_valid && cycles - t0 < 600) @(negedge clk);
        check(cycles - t0 >= 304 && cycles - t0 <= 312, "R10", cycles - t0, 308);
        drive(1'b1, 20);

        // R1 reset in mid-frame
        drive(1'b0, 100);
        #1 rst_n = 1'b0;
        @(negedge clk);
        check(rx_valid == 0 && rx_data == 0 && rx_frame_err == 0, "R1", rx_data, 0);
        rx_line = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        drive(1'b1, 20);
        send(8'h9E, 1'b1, 1'b0);
        drive(1'b1, 40);
        @(negedge clk);
        check(cap_data == 8'h9E, "R3", cap_data, 8'h9E);

        finish_up();
    end

    initial begin
        while (cycles < 150_000) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150_000);
        finish_up();
    end
endmodule